// File: doc/BRIEF.md
# Half-Duplex Serial ADC Read Controller

This block is the master side of a read from a 10-bit serial analog-to-digital converter that uses a single bidirectional data wire, a serial clock and an active-low chip select. The host pulses `start` with a device index, a single-ended/differential flag, an odd/sign channel flag and a bit-order flag. The controller opens a frame and shifts out a four-bit command. It then releases the data wire partway through the fourth clock period and clocks in the converter's reply.

Each serial clock half-period lasts a programmable number of system-clock cycles, so a slower setting also stretches the converter's sampling window. The reply begins with one null bit, which is discarded. The ten result bits follow, most significant first. The result is presented right-aligned and also split into an upper and a lower byte. Several converters can share the clock and data wires, and one chip-select output per device picks which one is addressed.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, every `cs_n` bit is 1, `sclk` is 0, `sd_oe` is 0, `busy` and `done` are 0, and `result`, `res_hi` and `res_lo` read 0 until the first frame completes.
- R2: A `start` seen while idle opens a frame. All `cs_n` bits stay high for one half-period after the accepting edge. Then only `cs_n[dev_sel]` goes low. It returns high at the end of the frame, and exactly 15 rising `sclk` edges occur while it is low.
- R3: The four command bits reach `sd_o` in this order: 1, `sgl_diff`, `odd_sign`, `msb_first`. Each bit is set up while `sclk` is low before its rising edge, and it holds steady while `sclk` is high.
- R4: `sd_oe` is 1 from the moment chip select falls until one system cycle after the 4th rising `sclk` edge. It drops while `sclk` is still high, so it is 0 before the 4th falling edge, and it stays 0 for the rest of the frame.
- R5: `sd_i` is sampled on the last system cycle before each of rising edges 5 to 15. The first of these samples is a null bit and is discarded. The remaining ten samples are result bits B9 down to B0.
- R6: `result[9:0]` holds B9..B0, with B9 in bit 9.
- R7: `res_hi` holds B9..B2, with B9 in bit 7. `res_lo` holds B1 in bit 7 and B0 in bit 6, and bits 5..0 are 0.
- R8: While chip select is low, every high phase and every low phase of `sclk` lasts max(`half_div`,1)+1 system cycles.
- R9: `busy` is 1 from the cycle after the accepting edge until chip select returns high. `done` is a one-cycle pulse in the cycle after chip select returns high, and `busy` is 0 in that cycle.
- R10: A `start` seen while `busy` is 1 is ignored. The running frame keeps its device, command and result, and no further frame follows it.
- R11: `sclk` is 0 whenever all `cs_n` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read; acted on only when idle |
| dev_sel | input | 2 | Index of the converter to address |
| sgl_diff | input | 1 | Single-ended (1) or differential (0) command bit |
| odd_sign | input | 1 | Odd/sign channel command bit |
| msb_first | input | 1 | Bit-order command bit |
| half_div | input | 8 | Serial clock half-period, minus one, in system cycles (0 is treated as 1) |
| sclk | output | 1 | Serial clock to the converters |
| cs_n | output | 4 | Active-low chip selects, one per converter |
| sd_o | output | 1 | Data value driven onto the shared wire |
| sd_oe | output | 1 | Output enable for the shared data wire |
| sd_i | input | 1 | Value read back from the shared data wire |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after a frame ends |
| result | output | 10 | Right-aligned conversion result |
| res_hi | output | 8 | Upper result byte B9..B2 |
| res_lo | output | 8 | Lower result byte: B1, B0, then six zeros |

## Verification
The assertions assume that `rst_n` is asserted before the first edge. They also assume that `half_div` does not change during a frame, since phase timing and the data hand-over are judged against one fixed half-period. The bench sets `half_div` only while the block is idle. It drives `sd_i` only after the 4th falling `sclk` edge of a frame, which is the point at which a real converter would take the wire. It pulses `start` during a frame only in the test that checks the request is ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   localparam int CMD_BITS = 4;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_CLO  = 3'd2,
      ST_CHI  = 3'd3,
      ST_DLO  = 3'd4,
      ST_DHI  = 3'd5,
      ST_POST = 3'd6
   } seq_st_t;
endpackage

// File: rtl/ser_half_timer.sv
module ser_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] lim,
   output logic             last
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim_eff;

   // a half-period of a single cycle would leave no room for the hand-over
   assign lim_eff = (lim == '0) ? DIV_W'(1) : lim;
   assign last    = (cnt == lim_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || last) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
   import adc_rd_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sgl_diff,
   input  logic odd_sign,
   input  logic msb_first,
   input  logic last,
   output logic restart,
   output logic sclk,
   output logic sd_o,
   output logic sd_oe,
   output logic cs_act,
   output logic busy,
   output logic done,
   output logic samp,
   output logic cap
);
   localparam int DAT_BITS = RES_W + 1;
   localparam int CNT_W    = $clog2(DAT_BITS + 1);

   seq_st_t             st;
   logic [CNT_W-1:0]    bitn;
   logic [CMD_BITS-1:0] cmd_q;
   logic                oe_q;
   logic                done_q;
   logic                cmd_last;
   logic                dat_last;

   assign cmd_last = (bitn == CNT_W'(CMD_BITS - 1));
   assign dat_last = (bitn == CNT_W'(DAT_BITS - 1));

   assign restart = (st == ST_IDLE) && start;
   assign sclk    = (st == ST_CHI) || (st == ST_DHI);
   assign cs_act  = (st == ST_CLO) || (st == ST_CHI) || (st == ST_DLO) || (st == ST_DHI);
   assign busy    = (st != ST_IDLE);
   assign done    = done_q;
   assign sd_oe   = oe_q;
   assign sd_o    = oe_q & cmd_q[CMD_BITS-1];
   assign samp    = (st == ST_DLO) && last;
   assign cap     = (st == ST_DHI) && last && dat_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         bitn   <= '0;
         cmd_q  <= '0;
         oe_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= (st == ST_POST);
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st    <= ST_PRE;
                  cmd_q <= {1'b1, sgl_diff, odd_sign, msb_first};
               end
            end
            ST_PRE: begin
               if (last) begin
                  st   <= ST_CLO;
                  bitn <= '0;
                  oe_q <= 1'b1;
               end
            end
            ST_CLO: begin
               if (last) st <= ST_CHI;
            end
            ST_CHI: begin
               // release the wire one cycle into the final command high phase
               if (cmd_last) oe_q <= 1'b0;
               if (last) begin
                  cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
                  if (cmd_last) begin
                     st   <= ST_DLO;
                     bitn <= '0;
                  end else begin
                     st   <= ST_CLO;
                     bitn <= bitn + CNT_W'(1);
                  end
               end
            end
            ST_DLO: begin
               if (last) st <= ST_DHI;
            end
            ST_DHI: begin
               if (last) begin
                  if (dat_last) begin
                     st <= ST_POST;
                  end else begin
                     st   <= ST_DLO;
                     bitn <= bitn + CNT_W'(1);
                  end
               end
            end
            ST_POST: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp,
   input  logic             cap,
   input  logic             sd_i,
   output logic [RES_W-1:0] res_q
);
   logic [RES_W-1:0] sh;

   // the null bit is pushed out of the top by the ten bits that follow it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         res_q <= '0;
      end else begin
         if (samp) sh <= {sh[RES_W-2:0], sd_i};
         if (cap)  res_q <= sh;
      end
   end
endmodule

// File: rtl/adc_res_pack.sv
module adc_res_pack #(
   parameter int RES_W = 10
) (
   input  logic [RES_W-1:0] res,
   output logic [7:0]       hi,
   output logic [7:0]       lo
);
   localparam int LO_BITS = RES_W - 8;
   localparam int PAD_W   = 8 - LO_BITS;

   assign hi = res[RES_W-1 -: 8];

   generate
      if (PAD_W == 0) begin : g_full
         assign lo = res[7:0];
      end else begin : g_pad
         assign lo = {res[LO_BITS-1:0], {PAD_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
   parameter int NUM_DEV = 4,
   parameter int DIV_W   = 8,
   parameter int RES_W   = 10,
   localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SEL_W-1:0]   dev_sel,
   input  logic               sgl_diff,
   input  logic               odd_sign,
   input  logic               msb_first,
   input  logic [DIV_W-1:0]   half_div,
   output logic               sclk,
   output logic [NUM_DEV-1:0] cs_n,
   output logic               sd_o,
   output logic               sd_oe,
   input  logic               sd_i,
   output logic               busy,
   output logic               done,
   output logic [RES_W-1:0]   result,
   output logic [7:0]         res_hi,
   output logic [7:0]         res_lo
);
   generate
      if (RES_W < 9 || RES_W > 16) begin : g_bad_res
         $error("RES_W must lie in 9..16 for the two-byte split");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("NUM_DEV must be at least 1");
      end
   endgenerate

   logic             restart;
   logic             last;
   logic             cs_act;
   logic             samp;
   logic             cap;
   logic [SEL_W-1:0] sel_q;

   ser_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .lim     (half_div),
      .last    (last)
   );

   adc_frame_seq #(.RES_W(RES_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sgl_diff  (sgl_diff),
      .odd_sign  (odd_sign),
      .msb_first (msb_first),
      .last      (last),
      .restart   (restart),
      .sclk      (sclk),
      .sd_o      (sd_o),
      .sd_oe     (sd_oe),
      .cs_act    (cs_act),
      .busy      (busy),
      .done      (done),
      .samp      (samp),
      .cap       (cap)
   );

   adc_rx_shift #(.RES_W(RES_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .samp  (samp),
      .cap   (cap),
      .sd_i  (sd_i),
      .res_q (result)
   );

   adc_res_pack #(.RES_W(RES_W)) u_pack (
      .res (result),
      .hi  (res_hi),
      .lo  (res_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else if (restart) sel_q <= dev_sel;
   end

   generate
      for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_cs
         assign cs_n[gi] = ~(cs_act && (sel_q == SEL_W'(gi)));
      end
   endgenerate
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
   parameter int NUM_DEV = 4,
   parameter int RES_W   = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               sclk,
   input logic [NUM_DEV-1:0] cs_n,
   input logic               sd_o,
   input logic               sd_oe
);
   localparam int RISES = 4 + RES_W + 1;
   localparam int RC_W  = $clog2(RISES + 2);

   logic [RC_W-1:0] rise_cnt;
   logic            sclk_q;
   logic            all_hi;

   assign all_hi = &cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         sclk_q   <= 1'b0;
      end else begin
         sclk_q <= sclk;
         if (all_hi) rise_cnt <= '0;
         else if (sclk && !sclk_q) rise_cnt <= rise_cnt + RC_W'(1);
      end
   end

   AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n)); // R2

   AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_hi) |-> (rise_cnt == RC_W'(RISES))); // R2

   AST_CMD_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && sd_oe) |-> $stable(sd_o)); // R3

   AST_RELEASE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_oe) |-> sclk); // R4

   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      all_hi |-> !sd_oe); // R4

   AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(all_hi) && !busy)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      all_hi |-> !sclk); // R11
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.NUM_DEV(NUM_DEV), .RES_W(RES_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .done  (done),
   .sclk  (sclk),
   .cs_n  (cs_n),
   .sd_o  (sd_o),
   .sd_oe (sd_oe)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] dev_sel = '0;
   logic       sgl_diff = 1'b0;
   logic       odd_sign = 1'b0;
   logic       msb_first = 1'b0;
   logic [7:0] half_div = 8'd2;
   logic       sclk;
   logic [3:0] cs_n;
   logic       sd_o;
   logic       sd_oe;
   logic       sd_i = 1'b0;
   logic       busy;
   logic       done;
   logic [9:0] result;
   logic [7:0] res_hi;
   logic [7:0] res_lo;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_rd_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
      .sgl_diff(sgl_diff), .odd_sign(odd_sign), .msb_first(msb_first),
      .half_div(half_div), .sclk(sclk), .cs_n(cs_n), .sd_o(sd_o),
      .sd_oe(sd_oe), .sd_i(sd_i), .busy(busy), .done(done),
      .result(result), .res_hi(res_hi), .res_lo(res_lo)
   );

   // converter reply: null bit first (set to 1 so a failure to discard shows), then B9..B0
   logic [10:0] conv_word = '0;

   // monitor state, written only by the monitor
   int         cyc = 0;
   int         rise_n, acc_cyc, cs_fall_cyc, rise4_cyc, oe_fall_cyc, cs_rise_cyc, done_cyc;
   int         done_cnt, run, hmin, hmax, lmin, lmax;
   logic       oe_fall_sclk, oe_at_fall4, done_busy;
   logic [3:0] cmd_cap, cs_seen;
   logic       psclk = 1'b0, poe = 1'b0, pall = 1'b1;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (start && !busy) begin
         rise_n = 0; acc_cyc = cyc; cs_fall_cyc = -1; rise4_cyc = -1;
         oe_fall_cyc = -1; cs_rise_cyc = -1; done_cyc = -1; done_cnt = 0;
         run = 0; hmin = 9999; hmax = 0; lmin = 9999; lmax = 0;
         oe_fall_sclk = 1'b0; oe_at_fall4 = 1'b1; done_busy = 1'b1;
         cmd_cap = '0; cs_seen = '0; sd_i = 1'b0;
      end
      cs_seen = cs_seen | ~cs_n;
      if (!(&cs_n)) begin
         if (pall) begin
            run = 1; cs_fall_cyc = cyc;
         end else if (sclk != psclk) begin
            if (psclk) begin
               if (run < hmin) hmin = run;
               if (run > hmax) hmax = run;
            end else begin
               if (run < lmin) lmin = run;
               if (run > lmax) lmax = run;
            end
            run = 1;
         end else begin
            run = run + 1;
         end
         if (sclk && !psclk) begin
            rise_n = rise_n + 1;
            if (rise_n <= 4) cmd_cap[4-rise_n] = sd_o;
            if (rise_n == 4) rise4_cyc = cyc;
         end
         if (!sclk && psclk && rise_n >= 4 && rise_n <= 14) begin
            if (rise_n == 4) oe_at_fall4 = sd_oe;
            sd_i = conv_word[14-rise_n];
         end
      end else if (!pall) begin
         cs_rise_cyc = cyc;
         if (psclk) begin
            if (run < hmin) hmin = run;
            if (run > hmax) hmax = run;
         end
      end
      if (poe && !sd_oe) begin
         oe_fall_cyc = cyc; oe_fall_sclk = sclk;
      end
      if (done) begin
         done_cnt = done_cnt + 1; done_cyc = cyc; done_busy = busy;
      end
      psclk = sclk; poe = sd_oe; pall = &cs_n;
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [1:0] sel, input logic sg, input logic od, input logic mf);
      @(posedge clk); #1;
      dev_sel = sel; sgl_diff = sg; odd_sign = od; msb_first = mf; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done_cnt > 0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_frame(input logic [1:0] sel, input logic sg, input logic od,
                              input logic mf, input logic [9:0] val, input int hd);
      int ph;
      ph = ((hd == 0) ? 1 : hd) + 1;
      chk(cs_seen == (4'b1 << sel), "R2 chip select", int'(cs_seen), int'(4'b1 << sel));
      chk(cs_fall_cyc - acc_cyc == ph + 1, "R2 select delay", cs_fall_cyc - acc_cyc, ph + 1);
      chk(rise_n == 15, "R2 rising edges", rise_n, 15);
      chk(cmd_cap == {1'b1, sg, od, mf}, "R3 command bits", int'(cmd_cap), int'({1'b1, sg, od, mf}));
      chk(oe_fall_cyc == rise4_cyc + 1 && oe_fall_sclk, "R4 release timing",
          oe_fall_cyc - rise4_cyc, 1);
      chk(!oe_at_fall4, "R4 released at 4th fall", int'(oe_at_fall4), 0);
      chk(result == val, "R5 R6 result", int'(result), int'(val));
      chk(res_hi == val[9:2], "R7 high byte", int'(res_hi), int'(val[9:2]));
      chk(res_lo == {val[1:0], 6'b0}, "R7 low byte", int'(res_lo), int'({val[1:0], 6'b0}));
      chk(hmin == ph && hmax == ph, "R8 high phase", hmax, ph);
      chk(lmin == ph && lmax == ph, "R8 low phase", lmax, ph);
      chk(done_cyc == cs_rise_cyc + 1 && done_cnt == 1 && !done_busy, "R9 done pulse",
          done_cyc - cs_rise_cyc, 1);
   endtask

   task automatic t_reset();
      chk(&cs_n && !sclk && !sd_oe, "R1 idle lines", int'({cs_n, sclk, sd_oe}), int'(6'b111100));
      chk(!busy && !done, "R1 flags", int'({busy, done}), 0);
      chk(result == '0 && res_hi == '0 && res_lo == '0, "R1 results", int'(result), 0);
      chk(!sclk, "R11 clock idle", int'(sclk), 0);
   endtask

   task automatic t_frame(input logic [1:0] sel, input logic sg, input logic od,
                          input logic mf, input logic [9:0] val, input int hd);
      half_div = 8'(hd);
      conv_word = {1'b1, val};
      pulse_start(sel, sg, od, mf);
      chk(busy, "R9 busy after accept", int'(busy), 1);
      wait_done();
      check_frame(sel, sg, od, mf, val, hd);
      chk(&cs_n && !sclk && !busy, "R11 idle after frame", int'({cs_n, sclk}), int'(5'b11110));
   endtask

   task automatic t_ignore();
      half_div = 8'd2;
      conv_word = {1'b1, 10'h2C3};
      pulse_start(2'd1, 1'b0, 1'b1, 1'b1);
      repeat (20) @(negedge clk);
      pulse_start(2'd3, 1'b1, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      pulse_start(2'd0, 1'b1, 1'b1, 1'b0);
      wait_done();
      check_frame(2'd1, 1'b0, 1'b1, 1'b1, 10'h2C3, 2);
      repeat (30) @(negedge clk);
      chk(done_cnt == 1 && !busy && &cs_n, "R10 no extra frame", done_cnt, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_frame(2'd0, 1'b1, 1'b0, 1'b1, 10'h2A5, 2);
      t_frame(2'd3, 1'b0, 1'b1, 1'b0, 10'h3FF, 0);
      t_frame(2'd1, 1'b1, 1'b1, 1'b1, 10'h000, 5);
      t_frame(2'd2, 1'b0, 1'b0, 1'b1, 10'h155, 3);
      t_ignore();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule